// File: doc/BRIEF.md
# Ring token controller for depth-cascaded FIFO slices

Each FIFO slice of a depth cascade carries one copy of this controller. All slices share one write strobe, one read strobe, one data-in bus and one data-out bus. The controller decides which slice is allowed to act on each shared access. Ownership is held as two tokens: one for writing and one for reading.

When the owning slice writes or reads its highest location, it passes the matching token on. It does this by pulling its expansion-out line low for that one access cycle. The next slice in the ring sees the low level on its expansion-in. It takes the write token if the write strobe is active in that cycle, and the read token if the read strobe is active. In cascade mode the write and read strobes must never be active in the same cycle, because this is how the two pulse kinds are told apart.

The operating role is read from two straps while reset is low:
- the expansion-in level;
- a first-load / rewind pin.

After reset, the first-load pin acts as a rewind request, but only in standalone mode. In standalone mode the shared output pin reports more-than-half occupancy instead of carrying pass pulses. The storage array sits outside the controller and is driven through the local enable and address ports.

Top module: `xring_slice_ctrl`

## Requirements
- R1: The role is latched on every clock edge while `rst_n` is low and held after reset, with this encoding on `mode`:
  - 0 (standalone) when `xin_n` is low;
  - 1 (first-load) when `xin_n` is high and `first_rt_n` is low;
  - 2 (follower) when `xin_n` and `first_rt_n` are both high.
- R2: `xo_hf_n` is high while `rst_n` is low, and in the first cycle after reset.
- R3: After reset, only the first-load slice holds the write and read tokens; followers hold neither.
- R4: A shared write asserts `wr_en` only on the slice holding the write token. A shared read asserts `rd_en` only on the slice holding the read token. In a ring, exactly one slice is enabled per accepted access.
- R5: In cascade mode, a write accepted at address DEPTH-1 drives `xo_hf_n` low in that same cycle. The slice then releases the write token and the write address wraps to 0.
- R6: In cascade mode, a read accepted at address DEPTH-1 drives `xo_hf_n` low in that same cycle. The slice then releases the read token and the read address wraps to 0.
- R7: A cascade slice that sees `xin_n` low while `wr_req` (or `rd_req`) is high holds the write (or read) token from the next cycle on.
- R8: In cascade mode:
  - `xo_hf_n` is low only in a token-pass cycle;
  - a low level on `first_rt_n` has no effect on addresses or data order.
- R9: In standalone mode:
  - both tokens are always held;
  - `xo_hf_n` never pulses;
  - `xo_hf_n` is low exactly when the slice stores more than DEPTH/2 words.
- R10: `full_n` is low only when the slice holds the write token and stores DEPTH words. `empty_n` is low only when the slice holds the read token and stores no word. A write to a full slice is refused, and so is a read from an empty one.
- R11: In standalone mode, `first_rt_n` low while no strobe is active does two things: it sets the read address to 0, and it sets the stored count to the write address, so that the words are read again from location 0.
- R12: Each accepted access advances its address by one, wrapping from DEPTH-1 to 0, and data leaves the ring in the order it entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; straps are sampled while low |
| xin_n | input | 1 | Expansion-in from the previous slice, or tied low for standalone |
| first_rt_n | input | 1 | First-load strap during reset; rewind request (standalone) after |
| wr_req | input | 1 | Shared write strobe |
| rd_req | input | 1 | Shared read strobe |
| wr_en | output | 1 | Local storage write enable |
| rd_en | output | 1 | Local storage read enable |
| wr_addr | output | AW | Local write address |
| rd_addr | output | AW | Local read address |
| full_n | output | 1 | Full flag, active low |
| empty_n | output | 1 | Empty flag, active low |
| xo_hf_n | output | 1 | Pass pulse (cascade) or half-full flag (standalone), active low |
| mode | output | 2 | Latched role code |

## Verification
A token held by the wrong slice shows up at the very next access. In that cycle, either two slices raise their enable together, or none does while a composite flag says there is room. The bench checks the count of enables on every access.

A missing or misplaced pass pulse shows up in the cycle of the access to location DEPTH-1. Two or more accesses later, a wrong pointer or count shows up as words out of order, or as a full or empty flag that disagrees with the word count the bench keeps.

// File: rtl/xring_pkg.sv
package xring_pkg;

  typedef enum logic [1:0] {
    MODE_SOLO = 2'd0,
    MODE_HEAD = 2'd1,
    MODE_TAIL = 2'd2
  } ring_mode_e;

  // Strap decode: expansion-in low selects standalone, otherwise the
  // first-load pin chooses between ring head and follower.
  function automatic ring_mode_e decode_mode(input logic xin_n,
                                             input logic first_n);
    if (!xin_n)
      return MODE_SOLO;
    else if (!first_n)
      return MODE_HEAD;
    else
      return MODE_TAIL;
  endfunction

endpackage

// File: rtl/xring_mode_latch.sv
module xring_mode_latch
  import xring_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xin_n,
  input  logic       first_n,
  output ring_mode_e mode_now,
  output ring_mode_e mode_q
);

  assign mode_now = decode_mode(xin_n, first_n);

  always_ff @(posedge clk) begin
    if (!rst_n)
      mode_q <= mode_now;
  end

  // R1: role frozen once reset is released
  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_q));

endmodule

// File: rtl/xring_token.sv
module xring_token #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          solo,
  input  logic          own_init,
  input  logic          strobe,
  input  logic          room,
  input  logic          pass_in,
  input  logic          rewind,
  output logic          own,
  output logic          en,
  output logic [AW-1:0] addr,
  output logic          pass_out
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return (a == LAST) ? '0 : a + 1'b1;
  endfunction

  logic at_last;

  assign at_last  = (addr == LAST);
  assign en       = strobe & own & room & ~rewind;
  assign pass_out = ~solo & en & at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own  <= own_init;
      addr <= '0;
    end else begin
      own <= solo | (own & ~pass_out) | pass_in;
      if (rewind)
        addr <= '0;
      else if (en)
        addr <= step_addr(addr);
    end
  end

  // R5 / R6: a pass that is not also received drops the token
  p_token_release_r5_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_out && !pass_in) |=> !own);

  // R7: a received pass grants the token
  p_token_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pass_in |=> own);

  // R4: ownership moves only through passes in cascade mode
  p_token_only_by_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!solo && !pass_in && !pass_out) |=> $stable(own));

  // R9: standalone keeps the token
  p_token_solo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    solo |=> own);

  // R12: address steps by one with wrap, otherwise holds
  p_addr_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rewind) |=> addr == step_addr($past(addr)));
  p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !rewind) |=> $stable(addr));

endmodule

// File: rtl/xring_occupancy.sv
module xring_occupancy #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          rewind,
  input  logic [AW-1:0] wr_addr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          half
);

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c,
                                               input logic inc,
                                               input logic dec);
    case ({inc, dec})
      2'b10:   return c + 1'b1;
      2'b01:   return c - 1'b1;
      default: return c;
    endcase
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign half  = (count > CW'(DEPTH / 2));

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (rewind)
      count <= CW'(wr_addr);
    else
      count <= next_count(count, wr_en, rd_en);
  end

  // R10: no write into a full slice, no read from an empty one
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_en);
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !rd_en);

  // R10: count follows accepted accesses
  p_count_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !rewind) |=> count == $past(count) + 1'b1);

endmodule

// File: rtl/xring_slice_ctrl.sv
module xring_slice_ctrl
  import xring_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xin_n,
  input  logic          first_rt_n,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          full_n,
  output logic          empty_n,
  output logic          xo_hf_n,
  output logic [1:0]    mode
);

  ring_mode_e    mode_now, mode_q;
  logic          solo, own_init, rewind;
  logic          wr_own, rd_own, wr_pass, rd_pass;
  logic          wr_recv, rd_recv;
  logic          occ_full, occ_empty, occ_half;
  logic [CW-1:0] occ_count;

  xring_mode_latch u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .xin_n    (xin_n),
    .first_n  (first_rt_n),
    .mode_now (mode_now),
    .mode_q   (mode_q)
  );

  assign solo     = (mode_q == MODE_SOLO);
  assign own_init = (mode_now != MODE_TAIL);
  assign rewind   = rst_n & solo & ~first_rt_n & ~wr_req & ~rd_req;
  assign wr_recv  = ~solo & ~xin_n & wr_req;
  assign rd_recv  = ~solo & ~xin_n & rd_req;

  xring_token #(.DEPTH(DEPTH), .AW(AW)) u_wr_tok (
    .clk      (clk),
    .rst_n    (rst_n),
    .solo     (solo),
    .own_init (own_init),
    .strobe   (wr_req),
    .room     (~occ_full),
    .pass_in  (wr_recv),
    .rewind   (1'b0),
    .own      (wr_own),
    .en       (wr_en),
    .addr     (wr_addr),
    .pass_out (wr_pass)
  );

  xring_token #(.DEPTH(DEPTH), .AW(AW)) u_rd_tok (
    .clk      (clk),
    .rst_n    (rst_n),
    .solo     (solo),
    .own_init (own_init),
    .strobe   (rd_req),
    .room     (~occ_empty),
    .pass_in  (rd_recv),
    .rewind   (rewind),
    .own      (rd_own),
    .en       (rd_en),
    .addr     (rd_addr),
    .pass_out (rd_pass)
  );

  xring_occupancy #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_occ (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rewind  (rewind),
    .wr_addr (wr_addr),
    .count   (occ_count),
    .full    (occ_full),
    .empty   (occ_empty),
    .half    (occ_half)
  );

  assign full_n  = ~(wr_own & occ_full);
  assign empty_n = ~(rd_own & occ_empty);
  assign mode    = mode_q;

  always_comb begin
    if (!rst_n)
      xo_hf_n = 1'b1;
    else if (solo)
      xo_hf_n = ~occ_half;
    else
      xo_hf_n = ~(wr_pass | rd_pass);
  end

  // R2: the shared pin is idle right after reset
  p_xo_idle_after_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> xo_hf_n);

  // R8: in a ring the pin only pulses during a strobed access
  p_xo_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!solo && !xo_hf_n) |-> (wr_req || rd_req));

  // R10: a raised flag blocks the matching local enable
  p_full_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !wr_en);
  p_empty_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !rd_en);

endmodule

// File: tb/xring_slice_ctrl_tb.sv
module xring_slice_ctrl_tb;

  localparam int N     = 3;
  localparam int DEPTH = 4;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // ring
  logic            c_wr = 1'b0, c_rd = 1'b0;
  logic [N-1:0]    r_first;
  logic [N-1:0]    r_wr_en, r_rd_en, r_full_n, r_empty_n, r_xo;
  logic [AW-1:0]   r_wa [N];
  logic [AW-1:0]   r_ra [N];
  logic [1:0]      r_mode [N];
  logic [7:0]      mem [N][DEPTH];

  for (genvar i = 0; i < N; i++) begin : g_ring
    localparam int PREV = (i + N - 1) % N;
    xring_slice_ctrl #(.DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .xin_n(r_xo[PREV]), .first_rt_n(r_first[i]),
      .wr_req(c_wr), .rd_req(c_rd), .wr_en(r_wr_en[i]), .rd_en(r_rd_en[i]),
      .wr_addr(r_wa[i]), .rd_addr(r_ra[i]), .full_n(r_full_n[i]),
      .empty_n(r_empty_n[i]), .xo_hf_n(r_xo[i]), .mode(r_mode[i]));
  end

  // standalone slice
  logic          s_first = 1'b1, s_wr = 1'b0, s_rd = 1'b0;
  logic          s_wr_en, s_rd_en, s_full_n, s_empty_n, s_xo;
  logic [AW-1:0] s_wa, s_ra;
  logic [1:0]    s_mode;
  logic [7:0]    s_mem [DEPTH];

  xring_slice_ctrl #(.DEPTH(DEPTH)) u_solo (
    .clk(clk), .rst_n(rst_n), .xin_n(1'b0), .first_rt_n(s_first),
    .wr_req(s_wr), .rd_req(s_rd), .wr_en(s_wr_en), .rd_en(s_rd_en),
    .wr_addr(s_wa), .rd_addr(s_ra), .full_n(s_full_n), .empty_n(s_empty_n),
    .xo_hf_n(s_xo), .mode(s_mode));

  // bench model of the ring
  logic [7:0] sb [64];
  int sb_head = 0, sb_tail = 0;
  int w_slice = 0, w_addr = 0, q_slice = 0, q_addr = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int onehot_idx(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic ring_write(input logic [7:0] d, input logic expect_ok);
    int k;
    logic [N-1:0] xo_exp;
    @(negedge clk); c_wr = 1'b1; #1;
    if (expect_ok) begin
      check("R4 one write enable", $countones(r_wr_en), 1);
      k = onehot_idx(r_wr_en);
      check("R3/R5 write slice", k, w_slice);
      check("R12 write address", r_wa[w_slice], w_addr);
      xo_exp = '1;
      if (w_addr == DEPTH - 1) xo_exp[w_slice] = 1'b0;
      check("R5/R8 write pass pulse", r_xo, xo_exp);
      if (k >= 0) mem[k][r_wa[k]] = d;
      sb[sb_tail % 64] = d; sb_tail++;
      w_addr++;
      if (w_addr == DEPTH) begin w_addr = 0; w_slice = (w_slice + 1) % N; end
    end else begin
      check("R10 write refused when full", r_wr_en, 0);
    end
    @(posedge clk); #1; c_wr = 1'b0;
  endtask

  task automatic ring_read(input logic expect_ok);
    int k;
    logic [N-1:0] xo_exp;
    @(negedge clk); c_rd = 1'b1; #1;
    if (expect_ok) begin
      check("R4 one read enable", $countones(r_rd_en), 1);
      k = onehot_idx(r_rd_en);
      check("R6 read slice", k, q_slice);
      check("R12 read address", r_ra[q_slice], q_addr);
      xo_exp = '1;
      if (q_addr == DEPTH - 1) xo_exp[q_slice] = 1'b0;
      check("R6/R8 read pass pulse", r_xo, xo_exp);
      if (k >= 0) check("R12 order", mem[k][r_ra[k]], sb[sb_head % 64]);
      sb_head++;
      q_addr++;
      if (q_addr == DEPTH) begin q_addr = 0; q_slice = (q_slice + 1) % N; end
    end else begin
      check("R10 read refused when empty", r_rd_en, 0);
    end
    @(posedge clk); #1; c_rd = 1'b0;
  endtask

  task automatic solo_write(input logic [7:0] d, input logic expect_ok, input logic exp_xo);
    @(negedge clk); s_wr = 1'b1; #1;
    check("R9/R10 solo write enable", s_wr_en, expect_ok);
    check("R9 no pulse in solo write", s_xo, exp_xo);
    if (s_wr_en) s_mem[s_wa] = d;
    @(posedge clk); #1; s_wr = 1'b0;
  endtask

  task automatic solo_read(input logic [7:0] d, input logic expect_ok);
    @(negedge clk); s_rd = 1'b1; #1;
    check("R10 solo read enable", s_rd_en, expect_ok);
    if (expect_ok && s_rd_en) check("R11 solo data", s_mem[s_ra], d);
    @(posedge clk); #1; s_rd = 1'b0;
  endtask

  task automatic test_reset();
    r_first = '1; r_first[0] = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 ring pin idle in reset", r_xo, {N{1'b1}});
    check("R2 solo pin idle in reset", s_xo, 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R2 ring pin idle after reset", r_xo, {N{1'b1}});
    check("R1 head mode", r_mode[0], 1);
    check("R1 follower mode", r_mode[1], 2);
    check("R1 follower mode", r_mode[2], 2);
    check("R1 standalone mode", s_mode, 0);
    check("R10 composite empty after reset", ~&r_empty_n, 1);
    check("R10 composite full after reset", ~&r_full_n, 0);
  endtask

  task automatic test_ring_fill();
    for (int j = 0; j < N * DEPTH; j++) ring_write(8'(8'h10 + j), 1'b1);
    check("R10 composite full", ~&r_full_n, 1);
    ring_write(8'hEE, 1'b0);
    for (int j = 0; j < N * DEPTH; j++) ring_read(1'b1);
    check("R10 composite empty", ~&r_empty_n, 1);
    ring_read(1'b0);
  endtask

  task automatic test_ring_wrap();
    for (int rnd = 0; rnd < 6; rnd++) begin
      for (int j = 0; j < 5; j++) ring_write(8'(8'h40 + rnd * 8 + j), 1'b1);
      if (rnd == 2) r_first[1] = 1'b0;  // R8: ignored by a cascade slice
      for (int j = 0; j < 5; j++) ring_read(1'b1);
      r_first[1] = 1'b1;
    end
    check("R12 ring drained", ~&r_empty_n, 1);
  endtask

  task automatic test_solo_rewind();
    solo_write(8'hA0, 1'b1, 1'b1);
    solo_write(8'hA1, 1'b1, 1'b1);
    solo_write(8'hA2, 1'b1, 1'b1);
    check("R9 solo half flag above half", s_xo, 0);
    solo_read(8'hA0, 1'b1);
    solo_read(8'hA1, 1'b1);
    @(negedge clk); s_first = 1'b0;
    @(negedge clk); s_first = 1'b1;
    check("R11 read address rewound", s_ra, 0);
    solo_read(8'hA0, 1'b1);
    solo_read(8'hA1, 1'b1);
    solo_read(8'hA2, 1'b1);
    check("R10 solo empty", s_empty_n, 0);
    solo_read(8'h00, 1'b0);
  endtask

  task automatic test_solo_flags();
    solo_write(8'hB0, 1'b1, 1'b1);      // address DEPTH-1: no pulse
    check("R12 solo write wrap", s_wa, 0);
    solo_write(8'hB1, 1'b1, 1'b1);
    solo_write(8'hB2, 1'b1, 1'b1);
    check("R9 half flag at three", s_xo, 0);
    solo_write(8'hB3, 1'b1, 1'b0);
    check("R10 solo full", s_full_n, 0);
    solo_write(8'hB4, 1'b0, 1'b0);
    solo_read(8'hB0, 1'b1);
    check("R10 solo full released", s_full_n, 1);
    check("R9 half flag still low", s_xo, 0);
    solo_read(8'hB1, 1'b1);
    check("R9 half flag released", s_xo, 1);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_ring_fill();
    test_ring_wrap();
    test_solo_rewind();
    test_solo_flags();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule